// File: doc/BRIEF.md
# BCD Calendar Clock with Freeze-and-Stage Register Window

This block keeps time of day and date in packed BCD. A set of internal running counters (seconds, minutes, hours, day of week, day of month, month, year, century) moves forward by one second on each pulse of a one-hertz tick input. Software never touches the running counters directly. It sees a second set of byte registers, the visible copies, which a small byte-wide register bus reaches at fixed offsets. The bus has no index port, and each access takes one cycle. Reads are combinational from the addressed copy.

A hold bit in the control register freezes the visible copies, so that software can read all eight bytes as one consistent snapshot while the running counters keep counting. While frozen, writes to the time bytes are staged in the visible copies. Clearing the hold bit commits the staged bytes into the running counters and then refreshes the whole visible set.

A four-state sequencer orders these actions. ST_RUN is the normal state. A tick moves it to ST_REFRESH, and a set hold bit moves it to ST_FROZEN. ST_REFRESH copies the running counters into the visible set for one cycle. It then goes to ST_FROZEN if hold is set, stays in ST_REFRESH if another tick advanced the counters, and otherwise returns to ST_RUN. ST_FROZEN accepts staged writes. When hold clears it goes to ST_COMMIT if any byte was written, and to ST_REFRESH if none was. ST_COMMIT loads the written bytes into the running counters and always continues to ST_REFRESH. A tick that arrives during ST_COMMIT is held back for one cycle and then applied.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the visible registers read 00 seconds, 00 minutes, 00 hours, day of week 01, day of month 01, month 01, year 00 and century 20 (BCD). The control register reads 0x00.
- R2: Offsets 0 to 7 hold, in order, seconds, minutes, hours, day of week, day of month, month, year and century. Offset 0xE is the control register, and only its bit 3 (hold) is stored; its other bits read 0. Every other offset reads 0x00. A read returns data in the same cycle the address is presented.
- R3: A tick pulse sampled at a clock edge advances the running counters at that edge. The visible copies show the new time one edge later. Without a tick or a commit the running counters do not change.
- R4: Seconds and minutes roll over from 59 to 00 with a carry to the next field. Hours roll over from 23 to 00 with a carry to the day.
- R5: Day of week counts 1 to 7 and wraps from 7 to 1 on every day carry.
- R6: Day of month wraps to 01 after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. February ends on 29 in a leap year and on 28 otherwise. A year is a leap year when it is a non-zero multiple of 4, or when it is 00 and the century is a multiple of 4.
- R7: Month wraps from 12 to 01 with a carry to the year. Year wraps from 99 to 00 and increments the century. Century wraps from 99 to 00.
- R8: While frozen, the visible copies do not change on ticks, but the running counters keep counting. After hold is cleared, the visible copies show every tick that arrived during the freeze.
- R9: If a tick and the write that sets hold arrive at the same edge, the pending refresh completes before the freeze, and the frozen copies show the new second.
- R10: Writes to offsets 0 to 7 made from the second cycle after hold is set read back at once. They are loaded into the running counters when hold is cleared, while fields that were not written keep their running values.
- R11: Writes to offsets 0 to 7 while hold is clear are ignored, and the visible copies keep the time.
- R12: A tick that arrives in the commit cycle is not lost. It is applied after the committed values, so the result is the written time plus one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz_i | input | 1 | One-cycle pulse, once per second |
| bus_we_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |

## Verification
On every cycle, the assertions check four things: the running counters stay still without a tick or a commit; the visible copies do not move while frozen or while no refresh is under way; staged bytes can only appear during the freeze; and a tick that meets the commit cycle is applied in the following cycle. Calendar arithmetic, such as month lengths, the leap-year rule and the carry chain from seconds up to the century, can only be shown by the bench's scenarios. The same holds for the values that appear after a commit and for the relative ordering of tick, hold and refresh. The bench compares these scenarios with its own calendar model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 8;
    localparam int BCD_W      = 8;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DOM  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;
    localparam int F_CENT = 7;

    typedef logic [NUM_FIELDS-1:0][BCD_W-1:0] cal_vec_t;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_REFRESH = 2'd1,
        ST_FROZEN  = 2'd2,
        ST_COMMIT  = 2'd3
    } seq_state_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return (v[7:4] >= 4'd9) ? 8'h00 : {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

    function automatic logic leap_year(input logic [7:0] yr, input logic [7:0] cent);
        logic [7:0] yb;
        logic [7:0] cb;
        yb = bcd_to_bin(yr);
        cb = bcd_to_bin(cent);
        if (yb == 8'd0)
            return (cb[1:0] == 2'd0);
        return (yb[1:0] == 2'd0);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr,
                                              input logic [7:0] cent);
        case (mon)
            8'h02:                      return leap_year(yr, cent) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] field_reset(input int idx, input logic [7:0] cent);
        if (idx == F_DOW || idx == F_DOM || idx == F_MON) return 8'h01;
        if (idx == F_CENT) return cent;
        return 8'h00;
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv_i,
    input  logic                  commit_i,
    input  logic [NUM_FIELDS-1:0] commit_mask_i,
    input  cal_vec_t              commit_val_i,
    output cal_vec_t              live_o
);

    cal_vec_t   live_q;
    cal_vec_t   nxt;
    logic       c_sec, c_min, c_day, c_mon, c_yr, c_cent;
    logic [7:0] mlen;

    always_comb begin
        nxt   = live_q;
        mlen  = month_days(live_q[F_MON], live_q[F_YEAR], live_q[F_CENT]);
        c_sec = (live_q[F_SEC] >= 8'h59);
        nxt[F_SEC] = c_sec ? 8'h00 : bcd_inc(live_q[F_SEC]);
        c_min = c_sec && (live_q[F_MIN] >= 8'h59);
        if (c_sec)
            nxt[F_MIN] = c_min ? 8'h00 : bcd_inc(live_q[F_MIN]);
        c_day = c_min && (live_q[F_HOUR] >= 8'h23);
        if (c_min)
            nxt[F_HOUR] = c_day ? 8'h00 : bcd_inc(live_q[F_HOUR]);
        c_mon = c_day && (live_q[F_DOM] >= mlen);
        if (c_day) begin
            nxt[F_DOW] = (live_q[F_DOW] >= 8'h07 || live_q[F_DOW] == 8'h00)
                         ? 8'h01 : bcd_inc(live_q[F_DOW]);
            nxt[F_DOM] = c_mon ? 8'h01 : bcd_inc(live_q[F_DOM]);
        end
        c_yr = c_mon && (live_q[F_MON] >= 8'h12);
        if (c_mon)
            nxt[F_MON] = c_yr ? 8'h01 : bcd_inc(live_q[F_MON]);
        c_cent = c_yr && (live_q[F_YEAR] >= 8'h99);
        if (c_yr)
            nxt[F_YEAR] = c_cent ? 8'h00 : bcd_inc(live_q[F_YEAR]);
        if (c_cent)
            nxt[F_CENT] = bcd_inc(live_q[F_CENT]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FIELDS; f++)
                live_q[f] <= field_reset(f, RESET_CENT);
        end else if (commit_i) begin
            for (int f = 0; f < NUM_FIELDS; f++)
                if (commit_mask_i[f])
                    live_q[f] <= commit_val_i[f];
        end else if (adv_i) begin
            live_q <= nxt;
        end
    end

    assign live_o = live_q;

    AST_LIVE_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !commit_i) |=> $stable(live_q)) else $error("running counters moved"); // R3

endmodule

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    input  logic dirty_any_i,
    output logic adv_o,
    output logic refresh_o,
    output logic commit_o,
    output logic frozen_o
);

    seq_state_t state_q, state_d;
    logic       tick_pend_q;
    logic       eff_tick;

    assign eff_tick = tick_i || tick_pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            tick_pend_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            tick_pend_q <= (state_q == ST_COMMIT) && eff_tick;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (eff_tick)    state_d = ST_REFRESH;
                else if (hold_i) state_d = ST_FROZEN;
            end
            ST_REFRESH: begin
                if (hold_i)        state_d = ST_FROZEN;
                else if (eff_tick) state_d = ST_REFRESH;
                else               state_d = ST_RUN;
            end
            ST_FROZEN: begin
                if (!hold_i) state_d = dirty_any_i ? ST_COMMIT : ST_REFRESH;
            end
            ST_COMMIT: state_d = ST_REFRESH;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        adv_o     = eff_tick && (state_q != ST_COMMIT);
        refresh_o = (state_q == ST_REFRESH);
        commit_o  = (state_q == ST_COMMIT);
        frozen_o  = (state_q == ST_FROZEN);
    end

    AST_TICK_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && tick_i) |=> adv_o) else $error("tick dropped in commit"); // R12

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_cal_pkg::*;
#(
    parameter int         ADDR_W     = 4,
    parameter int         CTRL_ADDR  = 14,
    parameter int         HOLD_BIT   = 3,
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [7:0]            wdata_i,
    input  logic                  refresh_i,
    input  logic                  frozen_i,
    input  cal_vec_t              live_i,
    output cal_vec_t              vis_o,
    output logic [NUM_FIELDS-1:0] dirty_o,
    output logic                  hold_o,
    output logic [7:0]            rdata_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    cal_vec_t              vis_q;
    logic [NUM_FIELDS-1:0] dirty_q;
    logic [NUM_FIELDS-1:0] field_wr;
    logic                  hold_q;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_dec
        assign field_wr[g] = we_i && frozen_i && (addr_i == ADDR_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NUM_FIELDS; f++)
                vis_q[f] <= field_reset(f, RESET_CENT);
            dirty_q <= '0;
            hold_q  <= 1'b0;
        end else begin
            if (refresh_i) begin
                vis_q   <= live_i;
                dirty_q <= '0;
            end else begin
                for (int f = 0; f < NUM_FIELDS; f++)
                    if (field_wr[f]) begin
                        vis_q[f]   <= wdata_i;
                        dirty_q[f] <= 1'b1;
                    end
            end
            if (we_i && addr_i == CTRL_A)
                hold_q <= wdata_i[HOLD_BIT];
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        for (int f = 0; f < NUM_FIELDS; f++)
            if (addr_i == ADDR_W'(f))
                rdata_o = vis_q[f];
        if (addr_i == CTRL_A)
            rdata_o = 8'(hold_q) << HOLD_BIT;
    end

    assign vis_o   = vis_q;
    assign dirty_o = dirty_q;
    assign hold_o  = hold_q;

    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_i && !(|field_wr)) |=> $stable(vis_q)) else $error("frozen copy moved"); // R8
    AST_IDLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen_i && !refresh_i) |=> $stable(vis_q)) else $error("copy moved outside freeze"); // R11
    AST_STAGE_ONLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dirty_q) |-> $past(frozen_i)) else $error("staged byte outside freeze"); // R10

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int         ADDR_W     = 4,
    parameter int         CTRL_ADDR  = 14,
    parameter int         HOLD_BIT   = 3,
    parameter logic [7:0] RESET_CENT = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o
);

    logic                  adv, refresh, commit, frozen, hold;
    logic [NUM_FIELDS-1:0] dirty;
    cal_vec_t              live, vis;

    rtc_seq_fsm u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_1hz_i),
        .hold_i      (hold),
        .dirty_any_i (|dirty),
        .adv_o       (adv),
        .refresh_o   (refresh),
        .commit_o    (commit),
        .frozen_o    (frozen)
    );

    rtc_time_core #(.RESET_CENT(RESET_CENT)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .adv_i         (adv),
        .commit_i      (commit),
        .commit_mask_i (dirty),
        .commit_val_i  (vis),
        .live_o        (live)
    );

    rtc_shadow_regs #(
        .ADDR_W     (ADDR_W),
        .CTRL_ADDR  (CTRL_ADDR),
        .HOLD_BIT   (HOLD_BIT),
        .RESET_CENT (RESET_CENT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .refresh_i (refresh),
        .frozen_i  (frozen),
        .live_i    (live),
        .vis_o     (vis),
        .dirty_o   (dirty),
        .hold_o    (hold),
        .rdata_o   (bus_rdata_o)
    );

endmodule

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int nchecks = 0;
    int nerr = 0;
    int m [8];
    int snap [8];

    always #2 clk = ~clk;

    rtc_calendar dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_1hz_i  (tick),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata)
    );

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(int mon, int y);
        bit lp;
        lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (mon == 2) return lp ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_advance();
        m[0]++;
        if (m[0] == 60) begin
            m[0] = 0; m[1]++;
            if (m[1] == 60) begin
                m[1] = 0; m[2]++;
                if (m[2] == 24) begin
                    m[2] = 0;
                    m[3] = (m[3] == 7) ? 1 : m[3] + 1;
                    m[4]++;
                    if (m[4] > mdays(m[5], m[7] * 100 + m[6])) begin
                        m[4] = 1; m[5]++;
                        if (m[5] == 13) begin
                            m[5] = 1; m[6]++;
                            if (m[6] == 100) begin
                                m[6] = 0; m[7] = (m[7] + 1) % 100;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        nchecks++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_advance();
        idle(2);
    endtask

    task automatic compare_vals(string tag, input int exp [8]);
        logic [7:0] d;
        for (int f = 0; f < 8; f++) begin
            bus_read(4'(f), d);
            check($sformatf("%s field %0d", tag, f), d, to_bcd(exp[f]));
        end
    endtask

    task automatic set_time(int s, int mi, int h, int dw, int dm, int mo, int y, int c);
        int v [8];
        v = '{s, mi, h, dw, dm, mo, y, c};
        bus_write(4'hE, 8'h08);
        idle(3);
        for (int f = 0; f < 8; f++) bus_write(4'(f), to_bcd(v[f]));
        bus_write(4'hE, 8'h00);
        idle(4);
        m = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4711));
        m = '{0, 0, 0, 1, 1, 1, 0, 20};
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        compare_vals("R1 reset", m);
        bus_read(4'hE, d); check("R1 control", d, 8'h00);

        // R2 unused offsets and control bit layout
        bus_read(4'h8, d); check("R2 offset 8", d, 8'h00);
        bus_read(4'hF, d); check("R2 offset F", d, 8'h00);
        bus_write(4'hE, 8'hF7);
        bus_read(4'hE, d); check("R2 control other bits", d, 8'h00);
        bus_write(4'hE, 8'hFF);
        bus_read(4'hE, d); check("R2 control hold bit", d, 8'h08);
        bus_write(4'hE, 8'h00);
        idle(4);

        // R11 write while not frozen is ignored
        bus_write(4'h0, 8'h37);
        bus_write(4'h4, 8'h15);
        idle(2);
        bus_read(4'h0, d); check("R11 seconds", d, 8'h00);
        bus_read(4'h4, d); check("R11 day", d, 8'h01);

        // R3 visible copy lags the tick by one edge
        @(negedge clk);
        addr = 4'h0; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        #1 check("R3 before refresh", rdata, 8'h00);
        @(negedge clk);
        #1 check("R3 after refresh", rdata, 8'h01);
        model_advance();
        pulse_tick();
        compare_vals("R3 two ticks", m);

        // R4 R5 R6: end of Feb in a common year, dow wrap
        set_time(59, 59, 23, 7, 28, 2, 23, 20);
        pulse_tick();
        compare_vals("R4 R5 R6 common Feb", m);
        // R6 leap year
        set_time(59, 59, 23, 3, 28, 2, 24, 20);
        pulse_tick();
        compare_vals("R6 leap 28", m);
        set_time(59, 59, 23, 4, 29, 2, 24, 20);
        pulse_tick();
        compare_vals("R6 leap 29", m);
        set_time(59, 59, 23, 1, 28, 2, 0, 21);
        pulse_tick();
        compare_vals("R6 century year not leap", m);
        set_time(59, 59, 23, 1, 28, 2, 0, 20);
        pulse_tick();
        compare_vals("R6 century year leap", m);
        set_time(59, 59, 23, 2, 30, 4, 5, 20);
        pulse_tick();
        compare_vals("R6 thirty day month", m);
        // R7 year and century carry
        set_time(59, 59, 23, 5, 31, 12, 99, 20);
        pulse_tick();
        compare_vals("R7 century carry", m);
        set_time(59, 59, 23, 5, 31, 12, 99, 99);
        pulse_tick();
        compare_vals("R7 century wrap", m);

        // R8 freeze holds the copy while counting continues
        set_time(58, 59, 23, 6, 31, 12, 30, 20);
        bus_write(4'hE, 8'h08);
        idle(3);
        snap = m;
        pulse_tick(); pulse_tick(); pulse_tick();
        compare_vals("R8 frozen", snap);
        bus_write(4'hE, 8'h00);
        idle(4);
        compare_vals("R8 released", m);

        // R9 tick and hold at the same edge
        set_time(10, 20, 5, 2, 3, 4, 50, 20);
        @(negedge clk);
        tick = 1'b1; we = 1'b1; addr = 4'hE; wdata = 8'h08;
        @(negedge clk);
        tick = 1'b0; we = 1'b0;
        model_advance();
        idle(3);
        snap = m;
        pulse_tick();
        compare_vals("R9 refresh completed", snap);
        bus_write(4'hE, 8'h00);
        idle(4);
        compare_vals("R9 released", m);

        // R10 staged write committed, other fields keep running
        set_time(10, 20, 5, 2, 3, 4, 50, 20);
        bus_write(4'hE, 8'h08);
        idle(3);
        bus_write(4'h1, 8'h42);
        bus_read(4'h1, d); check("R10 staged readback", d, 8'h42);
        pulse_tick(); pulse_tick();
        bus_write(4'hE, 8'h00);
        m[1] = 42;
        idle(4);
        compare_vals("R10 committed", m);

        // R12 tick during the commit cycle
        bus_write(4'hE, 8'h08);
        idle(3);
        bus_write(4'h0, 8'h10);
        bus_write(4'hE, 8'h00);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        m[0] = 10;
        model_advance();
        idle(4);
        compare_vals("R12 deferred tick", m);

        // random dates near rollovers (R4 R5 R6 R7)
        for (int i = 0; i < 30; i++) begin
            int c, y, mo, dm, h, mi, s, n;
            c  = $urandom_range(21, 19);
            y  = $urandom_range(99, 0);
            mo = $urandom_range(12, 1);
            dm = $urandom_range(1, 0) ? mdays(mo, c * 100 + y) : $urandom_range(mdays(mo, c * 100 + y), 1);
            h  = $urandom_range(1, 0) ? 23 : $urandom_range(23, 0);
            mi = $urandom_range(1, 0) ? 59 : $urandom_range(59, 0);
            s  = $urandom_range(2, 0) != 0 ? 59 : $urandom_range(59, 0);
            set_time(s, mi, h, $urandom_range(7, 1), dm, mo, y, c);
            n = $urandom_range(3, 1);
            for (int k = 0; k < n; k++) pulse_tick();
            compare_vals("R4 R6 R7 random", m);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule